// File: doc/BRIEF.md
# Reset and Boot Strap Sampler

This block turns an active-low external reset pin and an internal watchdog reset request into the core reset of a processor subsystem. The pin asserts the core reset at once, without a clock. Its release passes through a clock synchronizer, so the core leaves reset on a clock edge. A watchdog request holds the core in reset for as long as it is present. When the request ends, the core comes out of reset again.

Two configuration straps are judged over a fixed window of clock edges that ends at the release of the reset pin. One strap picks the width of the boot device. The other, active low, asks for every output driver of the chip to be disabled. The judged values are held until the next pin reset. A watchdog reset leaves them as they are. After either kind of reset, a counter holds back the first instruction fetch for a fixed number of cycles. A gated copy of the master clock is also provided. It stays low while the pin holds reset.

Top module: `rst_boot_ctrl`

## Requirements
- R1: While `rst_ni` is low, `core_rst_no` is low without waiting for a clock edge. After `rst_ni` rises, `core_rst_no` goes high on the second rising clock edge, provided no watchdog request is active.
- R2: After `rst_ni` rises, `fetch_en_o` goes high on the 80th rising clock edge, counting the first edge after the rise as edge 1. It stays low until then.
- R3: Each strap is latched low only if it was low on all 10 rising edges that come just before `rst_ni` rises. If it was high on any of those edges, it is latched high. Values seen on edges after the rise have no effect on the latched value.
- R4: `boot_8bit_o` shows the latched width strap. A value of 1 selects an 8-bit boot device and 0 selects a 16-bit boot device. The new value appears after the second edge following the release.
- R5: `tri_strap_ni` is active low. If it is latched low, `out_dis_o` is 1 (all outputs disabled). If it is latched high, `out_dis_o` is 0.
- R6: On every rising edge where `wdt_req_i` is high, the block drives `core_rst_no` low and `fetch_en_o` low. `core_rst_no` goes high again on the first edge where the request is low. `fetch_en_o` goes high on the 80th edge counted from that same edge.
- R7: A watchdog reset does not change `boot_8bit_o` or `out_dis_o`.
- R8: While `rst_ni` is low, the block ignores `wdt_req_i`. A pin release re-samples the straps even if a watchdog request is active at the same time.
- R9: `clk_echo_o` is low while `rst_ni` is low. It becomes a copy of `clk_i` from the first falling clock edge after `core_rst_no` could first rise (the second rising edge after release).
- R10: While `rst_ni` is low, `boot_8bit_o` is 1, `out_dis_o` is 0, and `fetch_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | External reset pin, active low |
| wdt_req_i | input | 1 | Watchdog reset request, active high |
| boot_width_i | input | 1 | Boot width strap (1 = 8-bit, 0 = 16-bit) |
| tri_strap_ni | input | 1 | Output-disable strap, active low |
| core_rst_no | output | 1 | Core reset, active low |
| fetch_en_o | output | 1 | First instruction fetch permitted |
| boot_8bit_o | output | 1 | Latched boot width, 1 = 8-bit device |
| out_dis_o | output | 1 | Global output-driver disable |
| clk_echo_o | output | 1 | Gated copy of the master clock |

## Verification
A pin reset and a watchdog request can be active in the same cycle, and a watchdog request can still be active on the edges where the pin release is being synchronized. The bench raises the watchdog request before the pin falls and holds it for several edges after the pin rises. It then checks three things: the straps are re-sampled from the pin window, the core reset is released only after the request drops, and the fetch counter restarts from the last edge of the request. The bench also drops the pin in the middle of a watchdog request. In every case a behavioural model in the bench runs cycle by cycle and is compared with every output.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned WIN_LEN     = 10;
  localparam int unsigned FETCH_DELAY = 80;
  localparam int unsigned STRAP_CNT   = 2;
  localparam int unsigned IDX_WIDTH   = 0;
  localparam int unsigned IDX_TRI     = 1;
endpackage

// File: rtl/rbc_pin_sync.sv
module rbc_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic early_o,
  output logic rel_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;

  // assert asynchronously, release through the flop chain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign early_o = sync_q[0];
  assign rel_o   = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-2] & ~sync_q[STAGES-1];
endmodule

// File: rtl/rbc_strap_win.sv
module rbc_strap_win #(
  parameter int unsigned WIN = 10,
  parameter int unsigned LAG = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  input  logic capture_i,
  output logic level_o
);
  localparam int unsigned DEPTH = WIN + LAG;

  logic [DEPTH-1:0] hist_q;
  logic             level_q;

  // free-running history, must keep sampling while the pin holds reset
  always_ff @(posedge clk_i) hist_q <= {hist_q[DEPTH-2:0], strap_i};

  // LAG newest samples were taken after the release and are skipped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        level_q <= 1'b1;
    else if (capture_i) level_q <= |hist_q[DEPTH-1:LAG];
  end

  assign level_o = level_q;
endmodule

// File: rtl/rbc_fetch_timer.sv
module rbc_fetch_timer #(
  parameter int unsigned DLY = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic wdt_req_i,
  output logic fetch_en_o,
  output logic wdt_hold_o
);
  localparam int unsigned            CNT_W = $clog2(DLY);
  localparam logic [CNT_W-1:0]       LAST  = CNT_W'(DLY - 2);

  logic [CNT_W-1:0] cnt_q;
  logic             fetch_q;
  logic             wdt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fetch_q <= 1'b0;
      wdt_q   <= 1'b0;
    end else begin
      wdt_q <= wdt_req_i;
      if (wdt_req_i) begin
        cnt_q   <= '0;
        fetch_q <= 1'b0;
      end else if (run_i && !wdt_q && !fetch_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) fetch_q <= 1'b1;
      end
    end
  end

  assign fetch_en_o = fetch_q;
  assign wdt_hold_o = wdt_q;
endmodule

// File: rtl/rbc_clk_echo.sv
module rbc_clk_echo (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);
  logic en_q;

  // enable changes only while the clock is low: no runt pulse
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign clk_o = clk_i & en_q;
endmodule

// File: rtl/rst_boot_ctrl.sv
module rst_boot_ctrl
  import rbc_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STAGES,
  parameter int unsigned WIN    = WIN_LEN,
  parameter int unsigned DLY    = FETCH_DELAY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdt_req_i,
  input  logic boot_width_i,
  input  logic tri_strap_ni,
  output logic core_rst_no,
  output logic fetch_en_o,
  output logic boot_8bit_o,
  output logic out_dis_o,
  output logic clk_echo_o
);
  logic                 pin_early, pin_rel, pin_rise;
  logic                 wdt_hold;
  logic [STRAP_CNT-1:0] strap_in, strap_lvl;

  rbc_pin_sync #(.STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .early_o(pin_early),
    .rel_o  (pin_rel),
    .rise_o (pin_rise)
  );

  assign strap_in[IDX_WIDTH] = boot_width_i;
  assign strap_in[IDX_TRI]   = tri_strap_ni;

  for (genvar g = 0; g < STRAP_CNT; g++) begin : g_strap
    rbc_strap_win #(.WIN(WIN), .LAG(STAGES - 1)) u_win (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strap_i  (strap_in[g]),
      .capture_i(pin_rise),
      .level_o  (strap_lvl[g])
    );
  end

  rbc_fetch_timer #(.DLY(DLY)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (pin_early),
    .wdt_req_i (wdt_req_i),
    .fetch_en_o(fetch_en_o),
    .wdt_hold_o(wdt_hold)
  );

  rbc_clk_echo u_echo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (pin_rel),
    .clk_o (clk_echo_o)
  );

  assign core_rst_no = pin_rel & ~wdt_hold;
  assign boot_8bit_o = strap_lvl[IDX_WIDTH];
  assign out_dis_o   = ~strap_lvl[IDX_TRI];

  assert_fetch_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_rst_no |-> !fetch_en_o);

  assert_fetch_after_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_en_o) |-> $past(core_rst_no));

  assert_wdt_holds_core_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_req_i |=> (!core_rst_no && !fetch_en_o));

  assert_wdt_keeps_straps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_hold && pin_rel) |=> ($stable(boot_8bit_o) && $stable(out_dis_o)));
endmodule

// File: tb/tb_rst_boot_ctrl.sv
`timescale 1ns/1ps
module tb_rst_boot_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int FD  = 80;
  localparam int WIN = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, wdt_req_i = 1'b0, boot_width_i = 1'b1, tri_strap_ni = 1'b1;
  logic core_rst_no, fetch_en_o, boot_8bit_o, out_dis_o, clk_echo_o;

  int compared = 0, mismatched = 0;
  string tag = "R10";

  // behavioural model state
  int pe = 0, k = 0;
  logic wq = 0, m_fetch = 0, m_boot = 1, m_dis = 0, m_en = 0, pend_w = 1, pend_d = 0;
  logic [1:0] hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_boot_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .wdt_req_i(wdt_req_i),
    .boot_width_i(boot_width_i), .tri_strap_ni(tri_strap_ni),
    .core_rst_no(core_rst_no), .fetch_en_o(fetch_en_o),
    .boot_8bit_o(boot_8bit_o), .out_dis_o(out_dis_o), .clk_echo_o(clk_echo_o)
  );

  task automatic chk(string req, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s [%s] t=%0t actual=%b expected=%b", req, tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      pe = 0; wq = 0; k = 0; m_fetch = 0; m_boot = 1; m_dis = 0; m_en = 0;
    end else begin
      if (pe < 1000) pe++;
      if (pe == 1) begin
        pend_w = 0; pend_d = 1;
        for (int i = 0; i < WIN; i++) begin
          if (hist[hist.size()-1-i][0]) pend_w = 1;
          if (hist[hist.size()-1-i][1]) pend_d = 0;
        end
      end
      if (pe == 2) begin m_boot = pend_w; m_dis = pend_d; end
      if (wdt_req_i) begin k = 0; m_fetch = 0; end
      else begin
        if (k < 1000) k++;
        if (k == FD) m_fetch = 1;
      end
      wq = wdt_req_i;
    end
    hist.push_back({tri_strap_ni, boot_width_i});
    if (hist.size() > 16) void'(hist.pop_front());
    #(CLK_PERIOD/4);
    chk("R1 R6 core_rst_no", core_rst_no, rst_ni && pe >= 2 && !wq);
    chk("R2 R6 fetch_en_o", fetch_en_o, m_fetch);
    chk("R3 R4 R7 boot_8bit_o", boot_8bit_o, m_boot);
    chk("R3 R5 R7 out_dis_o", out_dis_o, m_dis);
    chk("R9 clk_echo_o high phase", clk_echo_o, m_en && rst_ni);
  end

  always @(negedge clk) begin
    m_en = rst_ni && pe >= 2;
    #(CLK_PERIOD/4);
    chk("R9 clk_echo_o low phase", clk_echo_o, 1'b0);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R10 reset state, then plain release with straps high (R1 R2 R4)
    cyc(12);
    tag = "R1 R2 R4 straps high"; rst_ni = 1; cyc(90);

    // R3 R4 R5: both straps low on the whole window; high on the release edge is ignored
    tag = "R10"; rst_ni = 0; boot_width_i = 0; tri_strap_ni = 0; cyc(12);
    tag = "R3 R4 R5 all low"; rst_ni = 1; boot_width_i = 1; tri_strap_ni = 1; cyc(90);

    // R3: width high on the oldest window edge only, tri low only before the window
    tag = "R10"; rst_ni = 0; boot_width_i = 1; tri_strap_ni = 0; cyc(2);
    tri_strap_ni = 1; cyc(1);
    boot_width_i = 0; cyc(9);
    tag = "R3 partial window"; rst_ni = 1; cyc(90);

    // R6 R7: watchdog pulse with straps moved low, then a retrigger mid-count
    tag = "R6 R7 watchdog"; boot_width_i = 0; tri_strap_ni = 0; wdt_req_i = 1; cyc(5);
    wdt_req_i = 0; cyc(40);
    wdt_req_i = 1; cyc(1);
    wdt_req_i = 0; cyc(90);

    // R8: watchdog overlapping pin reset and its release
    tag = "R8 overlap"; wdt_req_i = 1; cyc(2);
    rst_ni = 0; boot_width_i = 0; tri_strap_ni = 0; cyc(12);
    rst_ni = 1; boot_width_i = 1; tri_strap_ni = 1; cyc(3);
    wdt_req_i = 0; cyc(90);

    // R8: pin drops during a watchdog request and releases after it ends
    tag = "R8 pin in watchdog"; wdt_req_i = 1; cyc(3);
    rst_ni = 0; cyc(4);
    wdt_req_i = 0; cyc(8);
    rst_ni = 1; cyc(90);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule